// File: doc/BRIEF.md
# Counted Host DMA Channel Controller

This block moves a programmed number of bytes between a buffer memory and a host port. Software loads a byte count and a starting buffer address through a small register write port. It then writes a control word that sets the channel enable and picks the direction. From then on the host paces the transfer with a request line. Each accepted request runs one buffer memory cycle, held until the memory grants it. The byte is then handed over with a one-cycle acknowledge. The address steps up by one and the count steps down by one.

Once the count reaches zero, the channel disables itself and latches a completion status bit. At that point the count reads zero and the address points one past the last byte moved. The status bit stays set until software clears it by writing a one to its bit position. Register contents are visible on dedicated output ports.

The sequencer has four states. `ST_IDLE` is the disabled state; it moves to `ST_WAIT_REQ` when enable is set. `ST_WAIT_REQ` moves to `ST_MEM_CYC` on a host request with a nonzero count, and back to `ST_IDLE` once enable clears. `ST_MEM_CYC` holds the memory request and moves to `ST_ACK_HOST` on grant. `ST_ACK_HOST` acknowledges the host, steps the counters and always returns to `ST_WAIT_REQ`.

Top module: `hdma_chan_ctrl`

## Requirements
- R1: After reset, count, address, enable, direction and the completion bit are all zero, and neither mem_req nor host_ack is asserted.
- R2: A register write goes to count at select 0, to address at select 1, and to control at select 2, where bit 0 is enable and bit 1 is direction. Writes to count, address and control are ignored while enable is 1.
- R3: When enable is 1 and count is nonzero, a host request starts a memory cycle. mem_req stays high with mem_addr equal to the address until mem_gnt. Direction 0 reads the buffer (mem_we=0). Direction 1 writes the buffer (mem_we=1) with the host byte sampled when the request is accepted.
- R4: In the cycle after mem_gnt, host_ack is high for exactly one cycle. In direction 0, host_rdata then carries the byte that the memory returned with the grant.
- R5: Each acknowledged byte lowers count by one and raises address by one, modulo 2^16, so 0xFFFF is followed by 0x0000.
- R6: When enable is 1 and count is zero, the next clock clears enable and sets the completion bit (select 3, bit 3). This applies both after the last byte and when the channel is enabled with a zero count.
- R7: The completion bit stays set until a write to select 3 with bit 3 equal to 1. A write to select 3 with bit 3 equal to 0 leaves it set.
- R8: A host request while enable is 0, or while count is zero, starts no memory cycle and changes neither count nor address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_sel | input | 2 | Register select (0 count, 1 address, 2 control, 3 status) |
| cpu_wdata | input | 16 | Register write data |
| host_req | input | 1 | Host transfer request, level |
| host_wdata | input | 8 | Byte from host (direction 1) |
| host_ack | output | 1 | One-cycle byte acknowledge to host |
| host_rdata | output | 8 | Byte to host (direction 0) |
| mem_req | output | 1 | Buffer memory cycle request |
| mem_we | output | 1 | Memory write when 1 |
| mem_addr | output | 16 | Buffer memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_gnt | input | 1 | One-cycle memory grant |
| mem_rdata | input | 8 | Memory read data, valid with grant |
| xfer_count | output | 16 | Remaining byte count |
| xfer_addr | output | 16 | Current buffer address |
| chan_en | output | 1 | Channel enable bit |
| chan_dir | output | 1 | Direction bit |
| done_flag | output | 1 | Completion status bit |

## Verification
The main function is exercised with transfers in both directions, with counts from one to five and with memory grants delayed by zero to three cycles. Read transfers show that the right buffer bytes reach the host in address order. Write transfers show that each host byte lands at its own address, which catches off-by-one stepping and latching of the wrong data. Transfers that start at 0xFFFE and 0xFFFF separate a correct 16-bit wrap from a saturating or widened address. Directed cases cover a request while disabled, enabling with a zero count, register writes during a transfer, and clearing the status bit with the clear bit at 0 and at 1.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_REQ = 2'd1,
        ST_MEM_CYC  = 2'd2,
        ST_ACK_HOST = 2'd3
    } hdma_state_e;

    localparam logic [1:0] SEL_COUNT = 2'd0;
    localparam logic [1:0] SEL_ADDR  = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_STAT  = 2'd3;

    localparam int BIT_EN   = 0;
    localparam int BIT_DIR  = 1;
    localparam int BIT_DONE = 3;
endpackage

// File: rtl/hdma_regs.sv
module hdma_regs
    import hdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int CPU_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_sel,
    input  logic [CPU_W-1:0]  cpu_wdata,
    input  logic              step,
    output logic [CNT_W-1:0]  count_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              en_o,
    output logic              dir_o,
    output logic              done_o
);
    logic cfg_wr;
    logic finish;
    logic clr_done;

    assign cfg_wr   = cpu_we && !en_o;
    assign finish   = en_o && (count_o == '0);
    assign clr_done = cpu_we && (cpu_sel == SEL_STAT) && cpu_wdata[BIT_DONE];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            addr_o  <= '0;
            en_o    <= 1'b0;
            dir_o   <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            if (step) begin
                count_o <= count_o - 1'b1;
                addr_o  <= addr_o + 1'b1;
            end else if (cfg_wr && cpu_sel == SEL_COUNT) begin
                count_o <= cpu_wdata[CNT_W-1:0];
            end else if (cfg_wr && cpu_sel == SEL_ADDR) begin
                addr_o <= cpu_wdata[ADDR_W-1:0];
            end

            if (cfg_wr && cpu_sel == SEL_CTRL) begin
                en_o  <= cpu_wdata[BIT_EN];
                dir_o <= cpu_wdata[BIT_DIR];
            end else if (finish) begin
                en_o <= 1'b0;
            end

            if (finish)
                done_o <= 1'b1;
            else if (clr_done)
                done_o <= 1'b0;
        end
    end

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_done) |=> done_o); // R7
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && !step && cpu_we) |=> ($stable(count_o) && $stable(addr_o) && $stable(dir_o))); // R2
endmodule

// File: rtl/hdma_fsm.sv
module hdma_fsm
    import hdma_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dir,
    input  logic              count_nz,
    input  logic              host_req,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              step
);
    hdma_state_e state_q, state_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (en) state_d = ST_WAIT_REQ;
            ST_WAIT_REQ: begin
                if (!en)                       state_d = ST_IDLE;
                else if (host_req && count_nz) state_d = ST_MEM_CYC;
            end
            ST_MEM_CYC:  if (mem_gnt) state_d = ST_ACK_HOST;
            ST_ACK_HOST: state_d = ST_WAIT_REQ;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (state_q == ST_WAIT_REQ && en && host_req && count_nz)
            data_q <= host_wdata;
        else if (state_q == ST_MEM_CYC && mem_gnt && !dir)
            data_q <= mem_rdata;
    end

    always_comb begin
        mem_req  = (state_q == ST_MEM_CYC);
        mem_we   = (state_q == ST_MEM_CYC) && dir;
        host_ack = (state_q == ST_ACK_HOST);
        step     = (state_q == ST_ACK_HOST);
    end

    assign mem_wdata  = data_q;
    assign host_rdata = data_q;

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack); // R4
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req); // R3
    AST_GNT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> host_ack); // R4
    AST_REQ_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> ($past(en) && $past(count_nz))); // R8
endmodule

// File: rtl/hdma_chan_ctrl.sv
module hdma_chan_ctrl
    import hdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int CPU_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_sel,
    input  logic [CPU_W-1:0]  cpu_wdata,
    input  logic              host_req,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  xfer_count,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              chan_en,
    output logic              chan_dir,
    output logic              done_flag
);
    logic step;

    hdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CPU_W(CPU_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (cpu_we),
        .cpu_sel   (cpu_sel),
        .cpu_wdata (cpu_wdata),
        .step      (step),
        .count_o   (xfer_count),
        .addr_o    (xfer_addr),
        .en_o      (chan_en),
        .dir_o     (chan_dir),
        .done_o    (done_flag)
    );

    hdma_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (chan_en),
        .dir        (chan_dir),
        .count_nz   (xfer_count != '0),
        .host_req   (host_req),
        .host_wdata (host_wdata),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .step       (step)
    );

    assign mem_addr = xfer_addr;

    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> (xfer_count == $past(xfer_count) - 1'b1)); // R5
    AST_STEP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> (xfer_addr == $past(xfer_addr) + 1'b1)); // R5
    AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && xfer_count == '0) |=> (!chan_en && done_flag)); // R6
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> $stable(mem_addr)); // R3
endmodule

// File: tb/tb_hdma_chan_ctrl.sv
module tb_hdma_chan_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_sel = 2'd0;
    logic [15:0] cpu_wdata = '0;
    logic        host_req = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic        host_ack;
    logic [7:0]  host_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_gnt;
    logic [7:0]  mem_rdata;
    logic [15:0] xfer_count, xfer_addr;
    logic        chan_en, chan_dir, done_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] bmem [256];
    logic [3:0] gdelay = 4'd0;
    int         wcnt;

    always #2.5 clk = ~clk;

    hdma_chan_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
        .host_req(host_req), .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .xfer_count(xfer_count), .xfer_addr(xfer_addr),
        .chan_en(chan_en), .chan_dir(chan_dir), .done_flag(done_flag)
    );

    assign mem_rdata = bmem[mem_addr[7:0]];

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i * 7 + 3);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_gnt <= 1'b0;
            wcnt    <= 0;
        end else if (mem_req && !mem_gnt) begin
            if (wcnt >= int'(gdelay)) begin
                mem_gnt <= 1'b1;
                wcnt    <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_gnt <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (mem_req && mem_gnt && mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        cpu_we = 1'b1; cpu_sel = sel; cpu_wdata = data;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic xfer_byte(input logic [7:0] wd, output logic [7:0] rd, output bit ok);
        int t;
        @(negedge clk);
        host_req = 1'b1; host_wdata = wd;
        ok = 1'b0; rd = '0; t = 0;
        while (t < 60) begin
            @(negedge clk);
            if (host_ack) begin ok = 1'b1; rd = host_rdata; break; end
            t++;
        end
        host_req = 1'b0;
    endtask

    // {dir, start address, count, grant delay, seed}
    localparam int NV = 5;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 16'h0010, 8'd4, 4'd0, 8'h00},
        {1'b1, 16'h0040, 8'd5, 4'd2, 8'hA5},
        {1'b0, 16'hFFFF, 8'd2, 4'd1, 8'h00},
        {1'b1, 16'hFFFE, 8'd3, 4'd0, 8'h3C},
        {1'b0, 16'h0080, 8'd1, 4'd3, 8'h00}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        bit ok;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(xfer_count == 0 && xfer_addr == 0, "R1 counters", {xfer_count, xfer_addr}, 0);
        chk(!chan_en && !chan_dir && !done_flag, "R1 flags", {chan_en, chan_dir, done_flag}, 0);
        chk(!mem_req && !host_ack, "R1 strobes", {mem_req, host_ack}, 0);

        // Vector table: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            logic        vdir;
            logic [15:0] va;
            logic [7:0]  vc, vs;
            {vdir, va, vc, gdelay, vs} = VEC[v];
            cpu_write(hdma_pkg::SEL_COUNT, 16'(vc));
            cpu_write(hdma_pkg::SEL_ADDR, va);
            chk(xfer_count == 16'(vc) && xfer_addr == va, "R2 load", {xfer_count, xfer_addr}, {16'(vc), va});
            cpu_write(hdma_pkg::SEL_CTRL, {14'd0, vdir, 1'b1});
            chk(chan_en && chan_dir == vdir, "R2 control", {chan_en, chan_dir}, {1'b1, vdir});
            for (int i = 0; i < int'(vc); i++) begin
                logic [15:0] a;
                logic [7:0]  exp_rd;
                a = va + 16'(i);
                exp_rd = bmem[a[7:0]];
                xfer_byte(vs + 8'(i), rd, ok);
                chk(ok, "R3 ack received", 32'(ok), 1);
                if (!vdir) chk(rd == exp_rd, "R4 read data", rd, exp_rd);
                @(negedge clk);
                chk(!host_ack, "R4 single ack", 32'(host_ack), 0);
                chk(xfer_count == 16'(vc) - 16'(i) - 16'd1, "R5 count step", xfer_count, 16'(vc) - 16'(i) - 16'd1);
                chk(xfer_addr == a + 16'd1, "R5 address step", xfer_addr, a + 16'd1);
            end
            repeat (2) @(negedge clk);
            chk(xfer_count == 0, "R6 count zero", xfer_count, 0);
            chk(xfer_addr == va + 16'(vc), "R6 address after last", xfer_addr, va + 16'(vc));
            chk(!chan_en && done_flag, "R6 done", {chan_en, done_flag}, 2'b01);
            if (vdir) begin
                for (int i = 0; i < int'(vc); i++) begin
                    logic [15:0] a;
                    a = va + 16'(i);
                    chk(bmem[a[7:0]] == vs + 8'(i), "R3 written byte", bmem[a[7:0]], vs + 8'(i));
                end
            end
            cpu_write(hdma_pkg::SEL_STAT, 16'h0000);
            chk(done_flag, "R7 kept on zero write", 32'(done_flag), 1);
            cpu_write(hdma_pkg::SEL_STAT, 16'h0008);
            chk(!done_flag, "R7 cleared", 32'(done_flag), 0);
        end

        // R8 request while disabled
        gdelay = 4'd0;
        cpu_write(hdma_pkg::SEL_COUNT, 16'd3);
        cpu_write(hdma_pkg::SEL_ADDR, 16'h0030);
        @(negedge clk);
        host_req = 1'b1;
        seen = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (mem_req || host_ack) seen = 1'b1;
        end
        host_req = 1'b0;
        chk(!seen, "R8 disabled no cycle", 32'(seen), 0);
        chk(xfer_count == 3 && xfer_addr == 16'h0030, "R8 disabled regs", {xfer_count, xfer_addr}, {16'd3, 16'h0030});

        // R6 R8 enable with zero count
        cpu_write(hdma_pkg::SEL_COUNT, 16'd0);
        @(negedge clk);
        host_req = 1'b1;
        cpu_we = 1'b1; cpu_sel = hdma_pkg::SEL_CTRL; cpu_wdata = 16'h0001;
        @(negedge clk);
        cpu_we = 1'b0;
        seen = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (mem_req || host_ack) seen = 1'b1;
        end
        host_req = 1'b0;
        chk(!seen, "R8 zero count no cycle", 32'(seen), 0);
        chk(xfer_addr == 16'h0030, "R8 zero count address", xfer_addr, 16'h0030);
        chk(!chan_en && done_flag, "R6 zero count done", {chan_en, done_flag}, 2'b01);
        cpu_write(hdma_pkg::SEL_STAT, 16'h0008);

        // R2 writes ignored while enabled
        cpu_write(hdma_pkg::SEL_COUNT, 16'd2);
        cpu_write(hdma_pkg::SEL_ADDR, 16'h0020);
        cpu_write(hdma_pkg::SEL_CTRL, 16'h0001);
        xfer_byte(8'h00, rd, ok);
        @(negedge clk);
        cpu_write(hdma_pkg::SEL_COUNT, 16'd99);
        cpu_write(hdma_pkg::SEL_ADDR, 16'h0000);
        cpu_write(hdma_pkg::SEL_CTRL, 16'h0002);
        chk(xfer_count == 1 && xfer_addr == 16'h0021, "R2 locked regs", {xfer_count, xfer_addr}, {16'd1, 16'h0021});
        chk(chan_en && !chan_dir, "R2 locked control", {chan_en, chan_dir}, 2'b10);
        xfer_byte(8'h00, rd, ok);
        chk(rd == bmem[8'h21], "R4 second byte after lock", rd, bmem[8'h21]);
        repeat (3) @(negedge clk);
        chk(!chan_en && done_flag && xfer_count == 0, "R6 after locked run", {chan_en, done_flag, xfer_count}, {2'b01, 16'd0});

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule